// File: doc/BRIEF.md
# CPU Port Memory Access Arbiter

This block joins a byte-wide, synchronous microprocessor bus to a group of switching memories whose access slots are owned by time-division-multiplexed (TDM) ports. Each bus cycle is either a register access or a memory access. The top bit of the latched address decides which. A memory access goes to the memory and page held in a control register, so a run of accesses within one page needs only one control write.

The TDM side grants the CPU access only on slots that the TDM ports leave free. Each memory has a slot strobe and a TDM-use flag. A slot counts as free only when its strobe is high and the TDM port is not using it in that cycle. A memory read waits for such a free slot and then raises the acknowledge. Memory writes go into a single-entry write buffer. A lone write is acknowledged at once, and the buffer empties on the next free slot of its memory. A second write waits until the first one has been committed.

The acknowledge stays high for as long as the request is held. It drops one cycle after chip-select or the strobe goes away.

Top module: `cpa_cpu_port`

## Requirements
- R1: After reset, register offset 0 reads 0x60 and offsets 1 to 5 read 0x00.
- R2: A register access (address MSB low) is acknowledged one cycle after the request, whatever the slot inputs are. Values written to offsets 0 to 5 read back unchanged.
- R3: Offset 8 returns status_i[7:0] and offset 9 returns {5'b0, status_i[10:8]}. Writes to these offsets have no effect.
- R4: Reserved offsets (6, 7 and 10 up to 127) read as zero, and a write to one of them changes no register.
- R5: With the address MSB high, the access targets memory ctrl[1:0], page ctrl[2 +: PAGE_W], byte addr_i[6:0], where ctrl is offset 1. Any number of accesses may follow without rewriting ctrl.
- R6: A memory read is acknowledged only in the cycle after a free slot of the selected memory, with the read data already valid on rdata_o.
- R7: A memory write that finds the write buffer empty is acknowledged one cycle after the request, without needing a slot.
- R8: The buffered write is committed on the next free slot of its own memory. A read of that memory serves the pending write first and so returns the new data.
- R9: A memory write that arrives while the buffer is full is not acknowledged until the earlier write has been committed. It is acknowledged in the cycle after that commit.
- R10: A slot whose TDM-use flag is high is taken by the TDM port and serves no CPU access.
- R11: If the selected memory never gets a slot, a read of it is never acknowledged. Dropping the request returns the block to idle, and register accesses keep working.
- R12: The acknowledge stays high while cs_i and the strobe are held, and falls one cycle after the request is withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe (wins over wr_i if both are high) |
| wr_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Latched address; the MSB selects memory (1) or register (0) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while ack_o is high after a read |
| ack_o | output | 1 | Data-transfer acknowledge |
| slot_i | input | NUM_MEM | Per-memory TDM access slot strobe |
| tdm_use_i | input | NUM_MEM | Per-memory flag: the TDM port uses this slot |
| status_i | input | STAT_W | Phase status word, readable at offsets 8 and 9 |

## Verification
The bench builds the block with ADDR_W=8, NUM_MEM=4 and STAT_W=11, and sets PAGE_W=1 so that the memories stay small. These values still leave two pages per memory, so page separation can be seen through the control register. With four independent slot strobes, the bench can starve one memory while the others keep ticking. Both the full-buffer and TDM-priority cases can be forced cycle by cycle by pulsing one strobe at a time.

// File: rtl/cpa_pkg.sv
package cpa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_WAIT = 2'd1,
        ST_WR_WAIT = 2'd2,
        ST_ACK     = 2'd3
    } cpa_state_e;

    localparam int REG_COUNT   = 6;
    localparam int RIDX_W      = 3;
    localparam int CTRL_OFS    = 1;
    localparam int STAT_LO_OFS = 8;
    localparam int STAT_HI_OFS = 9;

    function automatic logic [7:0] reg_reset_value(input int idx);
        return (idx == 0) ? 8'h60 : 8'h00;
    endfunction

endpackage

// File: rtl/cpa_reg_file.sv
module cpa_reg_file
    import cpa_pkg::*;
#(
    parameter int OFS_W  = 7,
    parameter int MEM_W  = 2,
    parameter int PAGE_W = 2,
    parameter int STAT_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic [7:0]        wdata_i,
    input  logic [STAT_W-1:0] status_i,
    output logic [7:0]        rdata_o,
    output logic [MEM_W-1:0]  mem_sel_o,
    output logic [PAGE_W-1:0] page_o
);
    localparam int HI_W = STAT_W - 8;

    logic [7:0] regs_q [REG_COUNT];
    logic       in_range;

    assign in_range = (ofs_i < OFS_W'(REG_COUNT));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_COUNT; i++) regs_q[i] <= reg_reset_value(i);
        end else if (we_i && in_range) begin
            regs_q[ofs_i[RIDX_W-1:0]] <= wdata_i;
        end
    end

    always_comb begin
        rdata_o = 8'h00;
        if (in_range)                              rdata_o = regs_q[ofs_i[RIDX_W-1:0]];
        else if (ofs_i == OFS_W'(STAT_LO_OFS))     rdata_o = status_i[7:0];
        else if (ofs_i == OFS_W'(STAT_HI_OFS))     rdata_o = {{(8-HI_W){1'b0}}, status_i[STAT_W-1:8]};
    end

    assign mem_sel_o = regs_q[CTRL_OFS][MEM_W-1:0];
    assign page_o    = regs_q[CTRL_OFS][MEM_W +: PAGE_W];

    assert_ctrl_only_by_own_offset_R4: assert property (@(posedge clk) disable iff (rst)
        (we_i && ofs_i != OFS_W'(CTRL_OFS)) |=> ($stable(mem_sel_o) && $stable(page_o)));

endmodule

// File: rtl/cpa_wbuf.sv
module cpa_wbuf #(
    parameter int NUM_MEM = 4,
    parameter int MEM_W   = 2,
    parameter int IDX_W   = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic [MEM_W-1:0]   load_mem_i,
    input  logic [IDX_W-1:0]   load_idx_i,
    input  logic [7:0]         load_data_i,
    input  logic [NUM_MEM-1:0] slot_free_i,
    output logic               valid_o,
    output logic [MEM_W-1:0]   mem_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic [7:0]         data_o,
    output logic               drain_o
);
    typedef struct packed {
        logic [MEM_W-1:0] mem;
        logic [IDX_W-1:0] idx;
        logic [7:0]       data;
    } wentry_t;

    wentry_t entry_q;
    logic    valid_q;

    assign drain_o = valid_q && slot_free_i[entry_q.mem];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            entry_q <= '0;
        end else if (load_i) begin
            valid_q <= 1'b1;
            entry_q <= '{mem: load_mem_i, idx: load_idx_i, data: load_data_i};
        end else if (drain_o) begin
            valid_q <= 1'b0;
        end
    end

    assign valid_o = valid_q;
    assign mem_o   = entry_q.mem;
    assign idx_o   = entry_q.idx;
    assign data_o  = entry_q.data;

    assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (rst)
        load_i |-> (!valid_o || drain_o));

    assert_drain_empties_R8: assert property (@(posedge clk) disable iff (rst)
        (drain_o && !load_i) |=> !valid_o);

endmodule

// File: rtl/cpa_mem_bank.sv
module cpa_mem_bank #(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [IDX_W-1:0] waddr_i,
    input  logic [7:0]       wdata_i,
    input  logic [IDX_W-1:0] raddr_i,
    output logic [7:0]       rdata_o
);
    localparam int DEPTH = 1 << IDX_W;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/cpa_cpu_port.sv
module cpa_cpu_port
    import cpa_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int NUM_MEM = 4,
    parameter int PAGE_W  = 2,
    parameter int STAT_W  = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_i,
    input  logic               rd_i,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [7:0]         wdata_i,
    output logic [7:0]         rdata_o,
    output logic               ack_o,
    input  logic [NUM_MEM-1:0] slot_i,
    input  logic [NUM_MEM-1:0] tdm_use_i,
    input  logic [STAT_W-1:0]  status_i
);
    localparam int OFS_W = ADDR_W - 1;
    localparam int MEM_W = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1;
    localparam int IDX_W = PAGE_W + OFS_W;

    cpa_state_e state_q;
    logic [7:0] rdata_q;

    logic               req, is_mem, is_wr;
    logic [NUM_MEM-1:0] slot_free;
    logic [MEM_W-1:0]   mem_sel;
    logic [PAGE_W-1:0]  page;
    logic [IDX_W-1:0]   cpu_idx;
    logic [7:0]         reg_rdata;
    logic               reg_we;
    logic               buf_valid, drain;
    logic [MEM_W-1:0]   buf_mem;
    logic [IDX_W-1:0]   buf_idx;
    logic [7:0]         buf_data;
    logic               read_grant, wr_accept;
    logic [7:0]         bank_rd [NUM_MEM];

    assign req       = cs_i && (rd_i || wr_i);
    assign is_mem    = addr_i[ADDR_W-1];
    assign is_wr     = wr_i && !rd_i;
    assign slot_free = slot_i & ~tdm_use_i;
    assign cpu_idx   = {page, addr_i[OFS_W-1:0]};
    assign reg_we    = (state_q == ST_IDLE) && req && !is_mem && is_wr;

    cpa_reg_file #(
        .OFS_W (OFS_W),
        .MEM_W (MEM_W),
        .PAGE_W(PAGE_W),
        .STAT_W(STAT_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we_i     (reg_we),
        .ofs_i    (addr_i[OFS_W-1:0]),
        .wdata_i  (wdata_i),
        .status_i (status_i),
        .rdata_o  (reg_rdata),
        .mem_sel_o(mem_sel),
        .page_o   (page)
    );

    assign read_grant = (state_q == ST_RD_WAIT) && req && slot_free[mem_sel]
                        && !(buf_valid && buf_mem == mem_sel);
    assign wr_accept  = req && is_wr && is_mem
                        && (state_q == ST_IDLE || state_q == ST_WR_WAIT)
                        && (!buf_valid || drain);

    cpa_wbuf #(
        .NUM_MEM(NUM_MEM),
        .MEM_W  (MEM_W),
        .IDX_W  (IDX_W)
    ) u_wbuf (
        .clk        (clk),
        .rst        (rst),
        .load_i     (wr_accept),
        .load_mem_i (mem_sel),
        .load_idx_i (cpu_idx),
        .load_data_i(wdata_i),
        .slot_free_i(slot_free),
        .valid_o    (buf_valid),
        .mem_o      (buf_mem),
        .idx_o      (buf_idx),
        .data_o     (buf_data),
        .drain_o    (drain)
    );

    for (genvar m = 0; m < NUM_MEM; m++) begin : g_bank
        cpa_mem_bank #(.IDX_W(IDX_W)) u_bank (
            .clk    (clk),
            .we_i   (drain && buf_mem == MEM_W'(m)),
            .waddr_i(buf_idx),
            .wdata_i(buf_data),
            .raddr_i(cpu_idx),
            .rdata_o(bank_rd[m])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rdata_q <= 8'h00;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req) begin
                    if (!is_mem) begin
                        if (!is_wr) rdata_q <= reg_rdata;
                        state_q <= ST_ACK;
                    end else if (!is_wr) begin
                        state_q <= ST_RD_WAIT;
                    end else if (wr_accept) begin
                        state_q <= ST_ACK;
                    end else begin
                        state_q <= ST_WR_WAIT;
                    end
                end
                ST_RD_WAIT: begin
                    if (!req) state_q <= ST_IDLE;
                    else if (read_grant) begin
                        rdata_q <= bank_rd[mem_sel];
                        state_q <= ST_ACK;
                    end
                end
                ST_WR_WAIT: begin
                    if (!req) state_q <= ST_IDLE;
                    else if (wr_accept) state_q <= ST_ACK;
                end
                ST_ACK: if (!req) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ack_o   = (state_q == ST_ACK);
    assign rdata_o = rdata_q;

    assert_reg_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && req && !is_mem) |=> ack_o);

    assert_read_waits_slot_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RD_WAIT && !read_grant) |=> !ack_o);

    assert_second_write_held_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WR_WAIT && buf_valid && !drain) |=> !ack_o);

    assert_ack_holds_R12: assert property (@(posedge clk) disable iff (rst)
        (ack_o && req) |=> ack_o);

    assert_ack_falls_R12: assert property (@(posedge clk) disable iff (rst)
        (ack_o && !req) |=> !ack_o);

endmodule

// File: tb/test_cpa_cpu_port.sv
module test_cpa_cpu_port;

    logic       clk = 1'b0;
    logic       rst;
    logic       cs, rd, wr;
    logic [7:0] addr, wdata;
    logic [7:0] rdata;
    logic       ack;
    logic [3:0] slot, tdm_use;
    logic [10:0] status;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cpa_cpu_port #(
        .ADDR_W (8),
        .NUM_MEM(4),
        .PAGE_W (1),
        .STAT_W (11)
    ) i_cpa_cpu_port (
        .clk      (clk),
        .rst      (rst),
        .cs_i     (cs),
        .rd_i     (rd),
        .wr_i     (wr),
        .addr_i   (addr),
        .wdata_i  (wdata),
        .rdata_o  (rdata),
        .ack_o    (ack),
        .slot_i   (slot),
        .tdm_use_i(tdm_use),
        .status_i (status)
    );

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_open(input bit is_rd, input logic [7:0] a, input logic [7:0] d);
        cs = 1'b1; rd = is_rd; wr = !is_rd; addr = a; wdata = d;
    endtask

    task automatic bus_close();
        cs = 1'b0; rd = 1'b0; wr = 1'b0;
        cyc();
    endtask

    task automatic reg_wr(input logic [7:0] ofs, input logic [7:0] d);
        bus_open(1'b0, ofs, d);
        cyc();
        check(ack == 1'b1, "R2", {7'd0, ack}, 8'h01);
        bus_close();
    endtask

    task automatic reg_rd(input logic [7:0] ofs, input logic [7:0] exp, input string tag);
        bus_open(1'b1, ofs, 8'h00);
        cyc();
        check(ack == 1'b1 && rdata == exp, tag, rdata, exp);
        bus_close();
    endtask

    task automatic mem_wr_fast(input logic [6:0] ofs, input logic [7:0] d);
        bus_open(1'b0, {1'b1, ofs}, d);
        cyc();
        check(ack == 1'b1, "R7", {7'd0, ack}, 8'h01);
        bus_close();
    endtask

    task automatic mem_rd(input int m, input logic [6:0] ofs, input logic [7:0] exp, input string tag);
        bus_open(1'b1, {1'b1, ofs}, 8'h00);
        cyc(); cyc(); cyc();
        check(ack == 1'b0, "R6", {7'd0, ack}, 8'h00);
        slot[m] = 1'b1;
        cyc();
        slot = '0;
        check(ack == 1'b1 && rdata == exp, tag, rdata, exp);
        bus_close();
    endtask

    task automatic drain(input int m);
        slot[m] = 1'b1;
        cyc();
        slot = '0;
    endtask

    task automatic t_reset();
        reg_rd(8'd0, 8'h60, "R1");
        for (int i = 1; i < 6; i++) reg_rd(8'(i), 8'h00, "R1");
    endtask

    task automatic t_regs();
        slot = 4'hF;
        for (int i = 0; i < 6; i++) reg_wr(8'(i), 8'(8'h21 * (i + 1)));
        for (int i = 0; i < 6; i++) reg_rd(8'(i), 8'(8'h21 * (i + 1)), "R2");
        slot = '0;
        reg_wr(8'd1, 8'h01);
        reg_wr(8'd5, 8'h00);
    endtask

    task automatic t_status();
        status = 11'h5A3;
        reg_rd(8'd8, 8'hA3, "R3");
        reg_rd(8'd9, 8'h05, "R3");
        reg_wr(8'd8, 8'h00);
        reg_wr(8'd9, 8'hFF);
        reg_rd(8'd8, 8'hA3, "R3");
        reg_rd(8'd9, 8'h05, "R3");
    endtask

    task automatic t_reserved();
        reg_wr(8'd6, 8'hFF);
        reg_rd(8'd6, 8'h00, "R4");
        reg_wr(8'd7, 8'hEE);
        reg_rd(8'd7, 8'h00, "R4");
        reg_rd(8'd10, 8'h00, "R4");
        reg_wr(8'h11, 8'hAA);
        reg_rd(8'd1, 8'h01, "R4");
        reg_rd(8'h7F, 8'h00, "R4");
    endtask

    task automatic t_mem_basic();
        reg_wr(8'd1, 8'h01);
        mem_wr_fast(7'd5, 8'h3C);
        drain(1);
        mem_rd(1, 7'd5, 8'h3C, "R8");
    endtask

    task automatic t_pages();
        reg_wr(8'd1, 8'h05);
        mem_wr_fast(7'd5, 8'hC3);
        drain(1);
        mem_rd(1, 7'd5, 8'hC3, "R5");
        reg_wr(8'd1, 8'h01);
        mem_rd(1, 7'd5, 8'h3C, "R5");
        mem_wr_fast(7'd6, 8'h44);
        drain(1);
        mem_rd(1, 7'd6, 8'h44, "R5");
        reg_wr(8'd1, 8'h02);
        mem_wr_fast(7'd5, 8'h77);
        drain(2);
        mem_rd(2, 7'd5, 8'h77, "R5");
        reg_wr(8'd1, 8'h01);
        mem_rd(1, 7'd5, 8'h3C, "R5");
    endtask

    task automatic t_pending_before_read();
        reg_wr(8'd1, 8'h01);
        mem_wr_fast(7'd7, 8'h5A);
        bus_open(1'b1, 8'h87, 8'h00);
        cyc();
        drain(1);
        check(ack == 1'b0, "R8", {7'd0, ack}, 8'h00);
        drain(1);
        check(ack == 1'b1 && rdata == 8'h5A, "R8", rdata, 8'h5A);
        bus_close();
    endtask

    task automatic t_second_write();
        bit early = 1'b0;
        reg_wr(8'd1, 8'h01);
        mem_wr_fast(7'd8, 8'h11);
        bus_open(1'b0, 8'h88, 8'h22);
        for (int i = 0; i < 4; i++) begin
            cyc();
            if (ack) early = 1'b1;
        end
        check(!early, "R9", {7'd0, early}, 8'h00);
        drain(1);
        check(ack == 1'b1, "R9", {7'd0, ack}, 8'h01);
        bus_close();
        drain(1);
        mem_rd(1, 7'd8, 8'h22, "R9");
    endtask

    task automatic t_tdm_priority();
        reg_wr(8'd1, 8'h01);
        bus_open(1'b1, 8'h88, 8'h00);
        cyc();
        slot[1] = 1'b1; tdm_use[1] = 1'b1;
        cyc();
        slot = '0; tdm_use = '0;
        check(ack == 1'b0, "R10", {7'd0, ack}, 8'h00);
        cyc();
        drain(1);
        check(ack == 1'b1 && rdata == 8'h22, "R10", rdata, 8'h22);
        bus_close();
    endtask

    task automatic t_ack_hold();
        bit dropped = 1'b0;
        bus_open(1'b1, 8'd0, 8'h00);
        cyc();
        for (int i = 0; i < 5; i++) begin
            if (!ack) dropped = 1'b1;
            cyc();
        end
        check(!dropped, "R12", {7'd0, dropped}, 8'h00);
        cs = 1'b0;
        cyc();
        check(ack == 1'b0, "R12", {7'd0, ack}, 8'h00);
        rd = 1'b0;
        cyc();
    endtask

    task automatic t_no_clock();
        bit seen = 1'b0;
        reg_wr(8'd1, 8'h03);
        bus_open(1'b1, 8'h80, 8'h00);
        slot = 4'b0111;
        for (int i = 0; i < 50; i++) begin
            cyc();
            if (ack) seen = 1'b1;
        end
        check(!seen, "R11", {7'd0, seen}, 8'h00);
        bus_close();
        slot = '0;
        reg_rd(8'd1, 8'h03, "R11");
    endtask

    initial begin
        for (int n = 0; n < 20000 && !done; n++) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %h expected %h", 8'h01, 8'h00);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cs = 1'b0; rd = 1'b0; wr = 1'b0;
        addr = '0; wdata = '0; slot = '0; tdm_use = '0; status = '0;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        t_reset();
        t_regs();
        t_status();
        t_reserved();
        t_mem_basic();
        t_pages();
        t_pending_before_read();
        t_second_write();
        t_tdm_priority();
        t_ack_hold();
        t_no_clock();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule